// File: doc/BRIEF.md
# Configurable Product-Term Macrocell

A single programmable logic cell whose behaviour comes entirely from a configuration word. Eight product terms are formed over a shared bus. The bus carries the term inputs plus one feedback bit. A selectable subset of the terms is ORed, and the result can be inverted. It then goes either straight to the pin or into a storage flop. The flop can act as D or T, can trigger on either clock edge, and takes either the global clock or a clock computed by a product term.

Three terms have extra roles when enabled. One is the local clock, one is an asynchronous clear, and one is the pin output enable. The feedback bit returns either the pad level or the flop output. The configuration word is captured on a global clock edge while the load strobe is high. A surrounding fabric would drive the term inputs, tie `pad_in` to the physical pad and use `pin_out`/`pin_oe` for a tri-state driver.

Top module: `pt_macrocell`

## Requirements
- R1: The configuration register captures `cfg_word` on a rising `gclk` edge when `cfg_load` is 1, and holds otherwise. A low `rst_n` at a rising `gclk` edge clears it to all zeros. In that state `pin_out`=0, `pin_oe`=1 and `fb_out`=0.
- R2: The bus bit order is term_in[0..5] then the feedback bit at index 6. Term t sets mask bit 2*i to require bus bit i = 1, and mask bit 2*i+1 to require bus bit i = 0. The term is the AND of its selected literals, and a term with no mask bit set is 0.
- R3: The sum is the OR of the terms whose `sum_sel` bit is set. When `inv` is 1 the sum is inverted before it reaches the flop or the pin.
- R4: With `bypass`=1, `pin_out` follows the polarity-adjusted sum without a clock. With `bypass`=0 it shows the flop output.
- R5: In D mode (`tff`=0) the flop loads the polarity-adjusted sum at its active clock edge, and at no other time.
- R6: In T mode (`tff`=1) the flop inverts its state at an active edge when the sum is 1, and keeps it when the sum is 0.
- R7: `fall`=0 makes the flop trigger on rising edges of its clock source, and `fall`=1 on falling edges.
- R8: With `lclk`=1 the flop is clocked by term 5 and ignores `gclk`. With `lclk`=0 it is clocked by `gclk`.
- R9: With `clr_en`=1, term 7 at 1 forces the flop to 0 at once and keeps it there through any clock edge. With `clr_en`=0 term 7 has no effect on the flop.
- R10: With `oe_en`=1, `pin_oe` equals term 6. With `oe_en`=0, `pin_oe` is 1.
- R11: With `fb_pin`=1 the feedback bit and `fb_out` equal `pad_in`. With `fb_pin`=0 they equal the flop output.
- R12: A low `rst_n` at an active flop clock edge clears the flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock; also clocks the configuration register |
| rst_n | input | 1 | Synchronous active-low reset |
| term_in | input | 6 | Term inputs, bus bits 0..5 |
| pad_in | input | 1 | Level seen on the pad, usable as feedback |
| cfg_word | input | 128 | Configuration word in `mc_cfg_t` layout |
| cfg_load | input | 1 | Capture strobe for `cfg_word` |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Pad output enable |
| fb_out | output | 1 | Feedback bit returned to the array |

## Verification
The clear term and an active clock edge can fall in the same cycle. The bench loads a 1 into the flop in D mode and raises the clear term between edges while the data term stays 1. It checks that the output drops to 0 before any edge and is still 0 after the following global edge. It then releases the clear and expects the next edge to load 1 again.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
// Shared constants and the configuration layout of the product-term macrocell.
// Assumes all modules are elaborated with the sizes given here.
package mc_pkg;
    localparam int unsigned MC_N_IN   = 6;
    localparam int unsigned MC_N_PT   = 8;
    localparam int unsigned MC_BUS_W  = MC_N_IN + 1;
    localparam int unsigned MC_MASK_W = 2 * MC_BUS_W;
    localparam int unsigned MC_CLK_PT = 5;
    localparam int unsigned MC_OE_PT  = 6;
    localparam int unsigned MC_CLR_PT = 7;

    typedef struct packed {
        logic [MC_N_PT-1:0][MC_MASK_W-1:0] mask;
        logic [MC_N_PT-1:0]                sum_sel;
        logic inv;
        logic tff;
        logic fall;
        logic lclk;
        logic bypass;
        logic fb_pin;
        logic clr_en;
        logic oe_en;
    } mc_cfg_t;

    localparam int unsigned MC_CFG_W = $bits(mc_cfg_t);
endpackage

// File: rtl/mc_cfg_reg.sv
`timescale 1ns/1ps
// Configuration holding register, written on the global clock.
// Assumes cfg_load is synchronous to gclk; reset is synchronous, active low.
module mc_cfg_reg #(
    parameter int unsigned CFG_W = 128
) (
    input  logic             gclk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_word,
    output logic [CFG_W-1:0] cfg_q
);
    // Capture the word on a strobe, clear on reset.
    always_ff @(posedge gclk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_load)
            cfg_q <= cfg_word;
    end

    p_cfg_capture_r1: assert property (@(posedge gclk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_load)) |-> (cfg_q == $past(cfg_word)));
    p_cfg_hold_r1: assert property (@(posedge gclk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_load)) |-> $stable(cfg_q));
endmodule

// File: rtl/mc_pt_array.sv
`timescale 1ns/1ps
// AND-OR array: per-term literal masks over {feedback, inputs}, selectable
// sum, polarity, and the three control terms broken out by index.
// Assumes mask bit 2*i selects bus[i] true and 2*i+1 selects it complemented.
module mc_pt_array #(
    parameter int unsigned N_IN    = 6,
    parameter int unsigned N_PT    = 8,
    parameter int unsigned CLK_IDX = 5,
    parameter int unsigned OE_IDX  = 6,
    parameter int unsigned CLR_IDX = 7,
    localparam int unsigned BUS_W  = N_IN + 1,
    localparam int unsigned MASK_W = 2 * BUS_W
) (
    input  logic [N_IN-1:0]             term_in,
    input  logic                        fb,
    input  logic [N_PT-1:0][MASK_W-1:0] mask,
    input  logic [N_PT-1:0]             sum_sel,
    input  logic                        inv,
    output logic                        sum_pol,
    output logic                        clk_pt,
    output logic                        oe_pt,
    output logic                        clr_pt
);
    logic [BUS_W-1:0] bus;
    logic [N_PT-1:0]  pt;

    assign bus = {fb, term_in};

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        logic [BUS_W-1:0] lit_ok;
        for (genvar i = 0; i < BUS_W; i++) begin : g_lit
            // A literal passes when unselected or when the bus bit matches.
            assign lit_ok[i] = (~mask[t][2*i] | bus[i]) & (~mask[t][2*i+1] | ~bus[i]);
        end
        // An unconnected term is forced low.
        assign pt[t] = (|mask[t]) & (&lit_ok);
    end

    // Sum of the selected terms followed by programmable inversion.
    assign sum_pol = (|(pt & sum_sel)) ^ inv;
    assign clk_pt  = pt[CLK_IDX];
    assign oe_pt   = pt[OE_IDX];
    assign clr_pt  = pt[CLR_IDX];
endmodule

// File: rtl/mc_storage.sv
`timescale 1ns/1ps
// Storage flop acting as D or T, with asynchronous active-high clear.
// Assumes ff_clk already carries the chosen source and edge sense;
// the synchronous reset only acts on an edge of ff_clk.
module mc_storage (
    input  logic ff_clk,
    input  logic clr,
    input  logic rst_n,
    input  logic tff,
    input  logic d,
    output logic q
);
    // Clear has priority over reset and over any clock event.
    always_ff @(posedge ff_clk or posedge clr) begin
        if (clr)
            q <= 1'b0;
        else if (!rst_n)
            q <= 1'b0;
        else if (tff)
            q <= q ^ d;
        else
            q <= d;
    end
endmodule

// File: rtl/pt_macrocell.sv
`timescale 1ns/1ps
// Configurable product-term macrocell: array, clock selection, storage flop,
// pin output mux, output enable and feedback selection.
// Assumes pad_in reflects the pad level; configuration changes only at loads.
module pt_macrocell
    import mc_pkg::*;
(
    input  logic                gclk,
    input  logic                rst_n,
    input  logic [MC_N_IN-1:0]  term_in,
    input  logic                pad_in,
    input  logic [MC_CFG_W-1:0] cfg_word,
    input  logic                cfg_load,
    output logic                pin_out,
    output logic                pin_oe,
    output logic                fb_out
);
    logic [MC_CFG_W-1:0] cfg_bits;
    mc_cfg_t             cfg;
    logic sum_pol, clk_pt, oe_pt, clr_pt;
    logic clk_src, ff_clk, clr_act, q;

    mc_cfg_reg #(.CFG_W(MC_CFG_W)) u_cfg (
        .gclk(gclk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_word(cfg_word), .cfg_q(cfg_bits)
    );

    assign cfg = mc_cfg_t'(cfg_bits);

    mc_pt_array #(
        .N_IN(MC_N_IN), .N_PT(MC_N_PT),
        .CLK_IDX(MC_CLK_PT), .OE_IDX(MC_OE_PT), .CLR_IDX(MC_CLR_PT)
    ) u_array (
        .term_in(term_in), .fb(fb_out), .mask(cfg.mask), .sum_sel(cfg.sum_sel),
        .inv(cfg.inv), .sum_pol(sum_pol), .clk_pt(clk_pt), .oe_pt(oe_pt), .clr_pt(clr_pt)
    );

    // Clock source and edge sense selection.
    assign clk_src = cfg.lclk ? clk_pt : gclk;
    assign ff_clk  = clk_src ^ cfg.fall;
    // Clear term gated by its enable.
    assign clr_act = cfg.clr_en & clr_pt;

    mc_storage u_ff (
        .ff_clk(ff_clk), .clr(clr_act), .rst_n(rst_n),
        .tff(cfg.tff), .d(sum_pol), .q(q)
    );

    // Pin value, enable and feedback muxes.
    assign pin_out = cfg.bypass ? sum_pol : q;
    assign pin_oe  = cfg.oe_en ? oe_pt : 1'b1;
    assign fb_out  = cfg.fb_pin ? pad_in : q;

    p_clear_holds_r9: assert property (@(posedge gclk) disable iff (!rst_n)
        clr_act |-> (q == 1'b0));
    p_d_capture_r5: assert property (@(posedge gclk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_load) && !cfg.tff && !cfg.lclk && !cfg.fall
         && !clr_act && !$past(clr_act)) |-> (q == $past(sum_pol)));
    p_t_toggle_r6: assert property (@(posedge gclk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_load) && cfg.tff && !cfg.lclk && !cfg.fall
         && !clr_act && !$past(clr_act)) |-> (q == ($past(q) ^ $past(sum_pol))));
endmodule

// File: tb/pt_macrocell_bench.sv
`timescale 1ns/1ps
module pt_macrocell_bench;
    import mc_pkg::*;

    logic                gclk = 1'b0;
    logic                rst_n = 1'b0;
    logic [MC_N_IN-1:0]  term_in = '0;
    logic                pad_in = 1'b0;
    logic [MC_CFG_W-1:0] cfg_word = '0;
    logic                cfg_load = 1'b0;
    logic                pin_out, pin_oe, fb_out;
    int                  n_chk = 0;
    int                  n_fail = 0;
    bit                  done = 1'b0;

    // Vectors: {term_in[5:0], pad_in, expected pin (inv=0), expected oe}
    localparam logic [8:0] VEC [8] = '{
        9'b000000_0_0_0, 9'b000001_0_1_0, 9'b000011_0_0_0, 9'b101100_0_1_1,
        9'b110000_1_1_1, 9'b010000_0_0_0, 9'b100100_0_0_1, 9'b001010_0_0_0
    };

    pt_macrocell u_pt_macrocell (
        .gclk(gclk), .rst_n(rst_n), .term_in(term_in), .pad_in(pad_in),
        .cfg_word(cfg_word), .cfg_load(cfg_load),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    always #2.5 gclk = ~gclk;

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    function automatic mc_cfg_t lit(mc_cfg_t c, int t, int i, bit comp);
        c.mask[t][2*i + int'(comp)] = 1'b1;
        return c;
    endfunction

    // Reset for two edges, then load a configuration; returns at edge+1ns.
    task automatic start_test(input mc_cfg_t c);
        @(posedge gclk); #1; rst_n = 1'b0; term_in = '0; pad_in = 1'b0;
        @(posedge gclk); @(posedge gclk); #1; rst_n = 1'b1;
        cfg_word = c; cfg_load = 1'b1;
        @(posedge gclk); #1; cfg_load = 1'b0;
    endtask

    task automatic step;
        @(posedge gclk); #1;
    endtask

    function automatic mc_cfg_t table_cfg(bit inv);
        mc_cfg_t c = '0;
        c = lit(c, 0, 0, 0); c = lit(c, 0, 1, 1);
        c = lit(c, 1, 2, 0); c = lit(c, 1, 3, 0);
        c = lit(c, 2, 6, 0); c = lit(c, 2, 4, 0);
        c = lit(c, 6, 5, 0);
        c.sum_sel = 8'b0000_0111;
        c.bypass = 1'b1; c.fb_pin = 1'b1; c.oe_en = 1'b1; c.inv = inv;
        return c;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        mc_cfg_t c;
        // Reset state (R1, R10, R11)
        step; step; #1;
        chk(pin_out, 1'b0, "R1", "reset pin_out");
        chk(pin_oe, 1'b1, "R10", "reset oe default");
        chk(fb_out, 1'b0, "R11", "reset feedback");

        // Table pass, both polarities (R2, R3, R4, R10, R11)
        for (int p = 0; p < 2; p++) begin
            start_test(table_cfg(p[0]));
            for (int v = 0; v < 8; v++) begin
                term_in = VEC[v][8:3]; pad_in = VEC[v][2];
                #1;
                chk(pin_out, VEC[v][1] ^ p[0], "R3", $sformatf("table pin v%0d inv%0d", v, p));
                chk(pin_oe, VEC[v][0], "R10", $sformatf("table oe v%0d", v));
                step;
            end
        end
        // Config hold without strobe (R1)
        cfg_word = '0; step; step;
        term_in = 6'b000001; pad_in = 1'b0; #1;
        chk(pin_out, 1'b0, "R1", "config held (inverted) without load");

        // Empty term is 0 (R2)
        c = '0; c.sum_sel = 8'b0000_0001; c.bypass = 1'b1;
        start_test(c);
        term_in = '1; #1;
        chk(pin_out, 1'b0, "R2", "empty term sums to 0");

        // D capture (R5, R4)
        c = '0; c = lit(c, 0, 0, 0); c.sum_sel = 8'b1;
        start_test(c);
        term_in = 6'b000001; #1;
        chk(pin_out, 1'b0, "R5", "no change before edge");
        step;
        chk(pin_out, 1'b1, "R5", "D load 1");
        term_in = '0; step;
        chk(pin_out, 1'b0, "R5", "D load 0");
        // Sync reset clears flop (R12)
        term_in = 6'b000001; step;
        chk(pin_out, 1'b1, "R12", "flop set before reset");
        rst_n = 1'b0; step;
        chk(pin_out, 1'b0, "R12", "reset clears flop");
        rst_n = 1'b1;

        // T mode (R6)
        c = '0; c = lit(c, 0, 0, 0); c.sum_sel = 8'b1; c.tff = 1'b1;
        start_test(c);
        term_in = 6'b000001; step;
        chk(pin_out, 1'b1, "R6", "toggle to 1");
        step;
        chk(pin_out, 1'b0, "R6", "toggle to 0");
        step;
        chk(pin_out, 1'b1, "R6", "toggle to 1 again");
        term_in = '0; step;
        chk(pin_out, 1'b1, "R6", "hold when sum 0");

        // Falling edge (R7)
        c = '0; c = lit(c, 0, 0, 0); c.sum_sel = 8'b1; c.fall = 1'b1;
        start_test(c);
        term_in = 6'b000001; #1;
        chk(pin_out, 1'b0, "R7", "before falling edge");
        #1.5;
        chk(pin_out, 1'b1, "R7", "after falling edge");
        step;
        term_in = '0; #1;
        chk(pin_out, 1'b1, "R7", "rising edge ignored");
        #1.5;
        chk(pin_out, 1'b0, "R7", "falling edge loads 0");

        // Local clock from term 5 (R8)
        c = '0; c = lit(c, 0, 0, 0); c = lit(c, 5, 1, 0); c.sum_sel = 8'b1; c.lclk = 1'b1;
        start_test(c);
        term_in = 6'b000001; step; step; step;
        chk(pin_out, 1'b0, "R8", "global edges ignored");
        term_in = 6'b000011; #1;
        chk(pin_out, 1'b1, "R8", "local clock edge loads");

        // Clear against clock in the same cycle (R9)
        c = '0; c = lit(c, 0, 0, 0); c = lit(c, 7, 2, 0); c.sum_sel = 8'b1; c.clr_en = 1'b1;
        start_test(c);
        term_in = 6'b000001; step;
        chk(pin_out, 1'b1, "R9", "flop set before clear");
        term_in = 6'b000101; #1;
        chk(pin_out, 1'b0, "R9", "clear acts without edge");
        step;
        chk(pin_out, 1'b0, "R9", "clear beats clock edge");
        term_in = 6'b000001; step;
        chk(pin_out, 1'b1, "R9", "load after clear released");
        c.clr_en = 1'b0;
        start_test(c);
        term_in = 6'b000101; step;
        chk(pin_out, 1'b1, "R9", "clear term ignored when disabled");

        // Feedback from flop and from pad (R11)
        c = '0; c = lit(c, 0, 6, 1); c.sum_sel = 8'b1;
        start_test(c);
        step;
        chk(fb_out, 1'b1, "R11", "flop feedback toggles to 1");
        step;
        chk(fb_out, 1'b0, "R11", "flop feedback toggles to 0");
        c = '0; c = lit(c, 0, 6, 0); c.sum_sel = 8'b1; c.fb_pin = 1'b1; c.bypass = 1'b1;
        start_test(c);
        pad_in = 1'b1; #1;
        chk(fb_out, 1'b1, "R11", "pad feedback 1");
        chk(pin_out, 1'b1, "R4", "bypass follows pad feedback");
        pad_in = 1'b0; #1;
        chk(pin_out, 1'b0, "R4", "bypass follows pad 0");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule